// File: doc/BRIEF.md
# Cache-Block Zeroing Store Engine

This engine carries out a zero-fill of one cache block on behalf of a hart. A request brings a byte address, the requester's privilege level, a flag saying whether the hart runs virtualized, and three enable bits taken from the machine, hypervisor and supervisor environment-configuration state. Before any store is made, the engine runs a layered permission check. The check either lets the operation go ahead or reports one of two faults: illegal instruction or virtual instruction.

When the operation is allowed, the address is rounded down to the start of its block. The engine then drives full-word zero stores across the whole block over a plain valid/ready write port. It writes every byte, whether or not the target region is cacheable or memory-mapped I/O. A one-cycle done pulse closes every request, whether it faulted or not. The hart issues a new request only while the busy output is low. Address translation, physical memory protection and trap delivery belong to the surrounding pipeline.

Top module: `cbz_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, busy, done, wrValid, faultIllegal and faultVirtual are all low.
- R2: The first store goes to reqAddr with its low log2(BLOCK_BYTES) bits cleared. Each following store goes to the previous store's address plus 4, and every store address has bits [1:0] equal to zero.
- R3: A permitted request produces exactly BLOCK_BYTES/4 stores. Each store has wrData equal to zero and wrStrb equal to 4'b1111. wrValid and wrAddr are held unchanged until wrReady is seen high.
- R4: done is high for exactly one cycle, in the cycle after the last store's handshake, with both fault outputs low and wrValid low. busy is low in the cycle that follows.
- R5: reqPriv is encoded as 0 = user, 1 = supervisor, 3 = machine. The value 2 is reserved and always gives an illegal-instruction fault.
- R6: A request below machine level with enMach clear gives an illegal-instruction fault. This check takes precedence over every other check. At machine level the request is permitted whatever the three enable bits are.
- R7: With reqVirt high, two cases give a virtual-instruction fault: supervisor or user level with enHyp clear, and user level with enSup clear. Supervisor level with enHyp set is permitted regardless of enSup.
- R8: With reqVirt low, a user-level request with enSup clear gives an illegal-instruction fault. A supervisor-level request with enMach set is permitted.
- R9: For a faulting request, no store is issued. done and exactly one fault output are high together for one cycle, in the cycle after the request is accepted.
- R10: A request is accepted only when busy is low. A reqValid raised while busy is high is ignored: it does not change the store addresses and does not start a further operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqAddr | input | ADDR_W | Byte address inside the block to clear |
| reqPriv | input | 2 | Privilege level: 0 user, 1 supervisor, 3 machine |
| reqVirt | input | 1 | Requester runs virtualized |
| enMach | input | 1 | Machine-level zeroing enable |
| enHyp | input | 1 | Hypervisor-level zeroing enable |
| enSup | input | 1 | Supervisor-level zeroing enable |
| busy | output | 1 | Engine is handling a request |
| done | output | 1 | One-cycle completion pulse |
| faultIllegal | output | 1 | Request ended with an illegal-instruction fault |
| faultVirtual | output | 1 | Request ended with a virtual-instruction fault |
| wrValid | output | 1 | Store request valid |
| wrAddr | output | ADDR_W | Store word address |
| wrData | output | 32 | Store data, always zero |
| wrStrb | output | 4 | Byte strobes |
| wrReady | input | 1 | Memory accepts the store |

## Verification
The bench builds the engine with ADDR_W = 32 and BLOCK_BYTES = 16. A four-word block keeps each fill short, so many requests fit in one run, and a four-bit alignment mask is still exposed by random addresses, including the all-ones address at the top of the space. Across both fault kinds and the permitted path, random stall patterns on wrReady exercise the hold-while-stalled behaviour on every word, including the last one before done.

// File: rtl/cbz_pkg.sv
`timescale 1ns/1ps
package cbz_pkg;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_ILLEGAL = 2'd1,
    FLT_VIRTUAL = 2'd2
  } fault_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture aligned base, clear word index
    logic advance;  // one store handshake completed
  } cbzStrobe_t;

  // Layered permission decision; the first failing layer wins
  function automatic fault_e permCheck(input logic [1:0] priv, input logic virt,
                                       input logic mEn, input logic hEn, input logic sEn);
    logic belowM;
    logic userOrSup;
    logic isUser;
    belowM    = (priv != PRIV_M);
    userOrSup = (priv == PRIV_U) || (priv == PRIV_S);
    isUser    = (priv == PRIV_U);
    if (priv == 2'd2)                                          return FLT_ILLEGAL;
    if (belowM && !mEn)                                        return FLT_ILLEGAL;
    if (virt && ((userOrSup && !hEn) || (isUser && !sEn)))     return FLT_VIRTUAL;
    if (isUser && !sEn)                                        return FLT_ILLEGAL;
    return FLT_NONE;
  endfunction

endpackage

// File: rtl/cbz_ctrl.sv
`timescale 1ns/1ps
module cbz_ctrl
  import cbz_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqPriv,
  input  logic       reqVirt,
  input  logic       enMach,
  input  logic       enHyp,
  input  logic       enSup,
  input  logic       wrReady,
  input  logic       lastWord,
  output cbzStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       faultIllegal,
  output logic       faultVirtual,
  output logic       wrValid
);

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_FIN} state_e;

  state_e stateQ;
  fault_e faultQ;
  fault_e reqFault;

  assign reqFault = permCheck(reqPriv, reqVirt, enMach, enHyp, enSup);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      faultQ <= FLT_NONE;
    end else begin
      case (stateQ)
        ST_IDLE: if (reqValid) begin
          faultQ <= reqFault;
          stateQ <= (reqFault == FLT_NONE) ? ST_FILL : ST_FIN;
        end
        ST_FILL: if (wrReady && lastWord) stateQ <= ST_FIN;
        ST_FIN: begin
          stateQ <= ST_IDLE;
          faultQ <= FLT_NONE;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load    = (stateQ == ST_IDLE) && reqValid && (reqFault == FLT_NONE);
    strobe.advance = (stateQ == ST_FILL) && wrReady;
  end

  assign busy         = (stateQ != ST_IDLE);
  assign wrValid      = (stateQ == ST_FILL);
  assign done         = (stateQ == ST_FIN);
  assign faultIllegal = done && (faultQ == FLT_ILLEGAL);
  assign faultVirtual = done && (faultQ == FLT_VIRTUAL);

  // R9
  fault_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultIllegal || faultVirtual) |-> (done && !wrValid));
  // R9
  one_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({faultIllegal, faultVirtual}));
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));
  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);
  // R6
  mach_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && (reqPriv != PRIV_M) && !enMach) |=> (faultIllegal && done));
  // R3
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> wrValid);

endmodule

// File: rtl/cbz_dpath.sv
`timescale 1ns/1ps
module cbz_dpath
  import cbz_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64   // power of two, at least 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cbzStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  output logic [3:0]        wrStrb,
  output logic              lastWord
);

  localparam int WORDS = BLOCK_BYTES / 4;
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BLOCK_BYTES - 1);

  logic [ADDR_W-1:0] baseQ;
  logic [IDX_W-1:0]  idxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      idxQ  <= '0;
    end else if (strobe.load) begin
      baseQ <= reqAddr & ALIGN_MASK;
      idxQ  <= '0;
    end else if (strobe.advance) begin
      idxQ  <= idxQ + 1'b1;
    end
  end

  assign wrAddr   = baseQ + (ADDR_W'(idxQ) << 2);
  assign wrData   = '0;
  assign wrStrb   = 4'b1111;
  assign lastWord = (idxQ == IDX_W'(WORDS - 1));

  // R2
  word_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> (wrAddr[1:0] == 2'b00));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !lastWord) |=> (wrAddr == $past(wrAddr) + ADDR_W'(4)));

endmodule

// File: rtl/cbz_engine.sv
`timescale 1ns/1ps
module cbz_engine
  import cbz_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqPriv,
  input  logic              reqVirt,
  input  logic              enMach,
  input  logic              enHyp,
  input  logic              enSup,
  output logic              busy,
  output logic              done,
  output logic              faultIllegal,
  output logic              faultVirtual,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  output logic [3:0]        wrStrb,
  input  logic              wrReady
);

  cbzStrobe_t strobe;
  logic       lastWord;

  cbz_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPriv(reqPriv),
    .reqVirt(reqVirt), .enMach(enMach), .enHyp(enHyp), .enSup(enSup),
    .wrReady(wrReady), .lastWord(lastWord), .strobe(strobe), .busy(busy),
    .done(done), .faultIllegal(faultIllegal), .faultVirtual(faultVirtual),
    .wrValid(wrValid)
  );

  cbz_dpath #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .wrAddr(wrAddr), .wrData(wrData), .wrStrb(wrStrb), .lastWord(lastWord)
  );

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> $stable(wrAddr));
  // R3
  zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrData == 32'd0 && wrStrb == 4'b1111));

endmodule

// File: tb/cbz_engine_test.sv
`timescale 1ns/1ps
module cbz_engine_test;

  localparam int ADDR_W = 32;
  localparam int BLK    = 16;
  localparam int WORDS  = BLK / 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0]        reqPriv = 2'd0;
  logic              reqVirt = 1'b0;
  logic              enMach = 1'b0, enHyp = 1'b0, enSup = 1'b0;
  logic              busy, done, faultIllegal, faultVirtual, wrValid;
  logic [ADDR_W-1:0] wrAddr;
  logic [31:0]       wrData;
  logic [3:0]        wrStrb;
  logic              wrReady = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cbz_engine #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLK)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqPriv(reqPriv), .reqVirt(reqVirt), .enMach(enMach), .enHyp(enHyp),
    .enSup(enSup), .busy(busy), .done(done), .faultIllegal(faultIllegal),
    .faultVirtual(faultVirtual), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrStrb(wrStrb), .wrReady(wrReady)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // 0 none, 1 illegal, 2 virtual
  function automatic int expFault(input logic [1:0] p, input logic v,
                                  input logic m, input logic h, input logic s);
    if (p == 2'd2) return 1;
    if (p != 2'd3 && !m) return 1;
    if (v && (((p == 2'd0 || p == 2'd1) && !h) || (p == 2'd0 && !s))) return 2;
    if (!v && p == 2'd0 && !s) return 1;
    return 0;
  endfunction

  function automatic string faultTag(input logic [1:0] p, input logic v, input logic m);
    if (p == 2'd2) return "R5";
    if (!m) return "R6";
    if (v) return "R7";
    return "R8";
  endfunction

  task automatic runOne(input logic [ADDR_W-1:0] a, input logic [1:0] p, input logic v,
                        input logic m, input logic h, input logic s,
                        input int readyPct, input bit poke, input string tag);
    int ef;
    logic [ADDR_W-1:0] base;
    ef = expFault(p, v, m, h, s);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqPriv = p; reqVirt = v;
    enMach = m; enHyp = h; enSup = s;
    @(negedge clk);
    reqValid = 1'b0;
    if (ef != 0) begin
      chk("R9", {tag, " done with fault"}, done, 1);
      chk(faultTag(p, v, m), "faultIllegal", faultIllegal, (ef == 1));
      chk(faultTag(p, v, m), "faultVirtual", faultVirtual, (ef == 2));
      chk("R9", "no store on fault", wrValid, 0);
      @(negedge clk);
      chk("R9", "done one cycle", done, 0);
      chk("R4", "idle after fault", busy, 0);
    end else begin
      base = a & ~ADDR_W'(BLK - 1);
      for (int w = 0; w < WORDS; w++) begin
        bit got;
        got = 1'b0;
        while (!got) begin
          chk("R3", {tag, " store valid"}, wrValid, 1);
          chk("R2", {tag, " store address"}, wrAddr, base + ADDR_W'(4 * w));
          chk("R3", "store data", {wrData, 28'd0, wrStrb}, {32'd0, 28'd0, 4'hF});
          chk("R4", "no early done", done, 0);
          if (poke && w == 0) begin
            reqValid = 1'b1; reqAddr = ~a; reqPriv = 2'd3;
          end else begin
            reqValid = 1'b0;
          end
          got = ($urandom_range(99) < readyPct);
          wrReady = got;
          @(negedge clk);
        end
      end
      wrReady = 1'b0;
      reqValid = 1'b0;
      chk("R4", {tag, " done after last store"}, done, 1);
      chk("R4", "faults low on success", {faultIllegal, faultVirtual}, 0);
      chk("R4", "store stops", wrValid, 0);
      @(negedge clk);
      chk("R4", "busy low after done", busy, 0);
      chk("R4", "done single cycle", done, 0);
      if (poke) begin
        @(negedge clk);
        chk("R10", "busy-time request ignored", {busy, wrValid}, 0);
      end
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {busy, done, wrValid, faultIllegal, faultVirtual}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "outputs after reset", {busy, done, wrValid, faultIllegal, faultVirtual}, 0);

    // directed corners
    runOne(32'h1234_567F, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 100, 1'b0, "R6 machine ignores enables");
    runOne(32'h0000_0040, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 100, 1'b0, "R6 precedence");
    runOne(32'h0000_0040, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 100, 1'b0, "R7 sup virt hyp off");
    runOne(32'h0000_0080, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 100, 1'b0, "R7 user virt sup off");
    runOne(32'h0000_0084, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 50,  1'b0, "R7 sup virt allowed");
    runOne(32'h0000_00C0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 100, 1'b0, "R8 user sup off");
    runOne(32'h0000_00C8, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 40,  1'b0, "R8 sup allowed");
    runOne(32'h0000_0100, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 100, 1'b0, "R5 reserved level");
    runOne(32'hFFFF_FFFF, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 30,  1'b0, "R2 top address");
    runOne(32'h0000_2000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 25,  1'b1, "R10 request while busy");

    // random mix
    for (int i = 0; i < 120; i++) begin
      logic [ADDR_W-1:0] a;
      logic [1:0] p;
      logic [3:0] r;
      a = ADDR_W'($urandom());
      p = 2'($urandom_range(3));
      r = 4'($urandom_range(15));
      runOne(a, p, r[0], r[1], r[2], r[3], 20 + 10 * (i % 8), (i % 10) == 3, "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule